// File: doc/BRIEF.md
# Event Ring Producer

This block posts completion and state-change events from the device into a circular event ring that lives in host memory. Internal sources offer events over a valid/ready stream. Each event carries a kind code, a channel number, a status byte and a transfer length. The block packs the event into a 64-bit descriptor and issues one memory write at the slot that the device pointer names. When that write is acknowledged, it advances the device pointer with wraparound and pulses an interrupt toward the host.

The ring uses an inverted pointer convention. The device produces at the read pointer and the host hands slots back by moving the write pointer. The host does this with an event doorbell write. The ring is full when the two pointers are equal, and no further event may be written then. The ring holds nothing for the host to service when the write pointer plus one, modulo the ring length, equals the read pointer.

The block keeps the ring base address, the ring length and local copies of both pointers. Software loads them through a configuration strobe before use. Back-pressure rules are as follows. `ev_ready` is low while the ring is full and while a descriptor write is outstanding. A producer holding `ev_valid` keeps its fields stable until the handshake, and no offered event is ever dropped. On the memory side, `mem_wvalid` stays high with a stable address and data until `mem_wready` is seen.

Top module: `evr_producer`

## Requirements
- R1: After reset, `ev_ready`, `mem_wvalid` and `irq` are low, and both `rd_ptr` and `wr_ptr` are zero.
- R2: A `cfg_load` pulse, given while no write is outstanding, loads the base, the length (2 to 2^IDX_W slots) and both pointers. From the next cycle, `ev_ready` is high exactly when the pointers differ.
- R3: While `rd_ptr` equals `wr_ptr`, `ev_ready` stays low and `mem_wvalid` stays low. An event held on the input during that time is written unchanged once a doorbell frees a slot.
- R4: The descriptor address is the ring base plus `rd_ptr` times EV_BYTES (16 by default).
- R5: The descriptor holds the transfer length in bits [63:48], the channel in [47:40], the status in [39:32] and the kind in [31:24]. Bits [23:0] are zero.
- R6: While `mem_wvalid` is high and `mem_wready` is low, the write request stays asserted with the same address and data.
- R7: `rd_ptr` advances only on the edge that completes a descriptor write. It steps from length-1 back to 0.
- R8: `irq` is a one-cycle pulse in the cycle after the write handshake, and it is never asserted otherwise.
- R9: A doorbell with a value below the ring length replaces `wr_ptr` on the next edge. A doorbell with a value at or above the length leaves `wr_ptr` unchanged.
- R10: At most one descriptor write is outstanding. `ev_ready` is low while `mem_wvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load ring configuration strobe |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | IDX_W+1 | Ring length in slots |
| cfg_rp | input | IDX_W | Initial device (read) pointer |
| cfg_wp | input | IDX_W | Initial host (write) pointer |
| db_valid | input | 1 | Event doorbell strobe |
| db_wp | input | IDX_W | New host write pointer |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_kind | input | 8 | Event kind code |
| ev_chan | input | 8 | Channel number |
| ev_status | input | 8 | Completion status |
| ev_xlen | input | 16 | Transfer length |
| mem_wvalid | output | 1 | Descriptor write request |
| mem_wready | input | 1 | Descriptor write acknowledged |
| mem_waddr | output | ADDR_W | Descriptor byte address |
| mem_wdata | output | 64 | Packed descriptor |
| irq | output | 1 | Host interrupt pulse |
| rd_ptr | output | IDX_W | Device pointer copy |
| wr_ptr | output | IDX_W | Host pointer copy |

## Verification
An event accepted on one edge shows up on the memory write port in the following cycle. The pointer step and the interrupt pulse appear in the cycle after the edge that sees `mem_wready`, and the interrupt drops one cycle later. Configuration and doorbell writes change the pointers, and so `ev_ready`, one cycle after their strobe. The bench drives all inputs on the falling edge and samples at those falling edges, so each check falls in exactly the cycle the pipeline count predicts. A reference model of both pointers tracks every accept and doorbell.

// File: rtl/evr_pkg.sv
package evr_pkg;
  parameter int KIND_W = 8;
  parameter int CHAN_W = 8;
  parameter int STAT_W = 8;
  parameter int XLEN_W = 16;
  parameter int DESC_W = 64;
  localparam int PAD_W = DESC_W - KIND_W - CHAN_W - STAT_W - XLEN_W;

  typedef struct packed {
    logic [XLEN_W-1:0] xfer_len;
    logic [CHAN_W-1:0] chan;
    logic [STAT_W-1:0] status;
    logic [KIND_W-1:0] kind;
    logic [PAD_W-1:0]  pad;
  } evr_desc_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } evr_state_e;
endpackage

// File: rtl/evr_ptr.sv
module evr_ptr #(
  parameter int IDX_W = 4,
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [IDX_W-1:0] cfg_rp,
  input  logic [IDX_W-1:0] cfg_wp,
  input  logic             db_valid,
  input  logic [IDX_W-1:0] db_wp,
  input  logic             adv,
  output logic [IDX_W-1:0] rp,
  output logic [IDX_W-1:0] wp,
  output logic             full
);
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] rp_q, wp_q;
  logic             at_last, db_ok;

  assign at_last = ({1'b0, rp_q} == (len_q - 1'b1));
  assign db_ok   = db_valid && ({1'b0, db_wp} < len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1) << IDX_W;
      rp_q  <= '0;
      wp_q  <= '0;
    end else if (cfg_load) begin
      len_q <= cfg_len;
      rp_q  <= cfg_rp;
      wp_q  <= cfg_wp;
    end else begin
      if (adv)   rp_q <= at_last ? '0 : rp_q + 1'b1;
      if (db_ok) wp_q <= db_wp;
    end
  end

  assign rp   = rp_q;
  assign wp   = wp_q;
  assign full = (rp_q == wp_q);

  // R7: device pointer never leaves the ring
  a_r7_rp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rp_q} < len_q));

  // R9: out-of-range doorbell leaves the host pointer alone
  a_r9_db_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && !cfg_load && ({1'b0, db_wp} >= len_q)) |=> (wp_q == $past(wp_q)));
endmodule

// File: rtl/evr_fmt.sv
module evr_fmt
  import evr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int EV_BYTES = 16,
  localparam int EV_SHIFT = $clog2(EV_BYTES)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [KIND_W-1:0] kind,
  input  logic [CHAN_W-1:0] chan,
  input  logic [STAT_W-1:0] status,
  input  logic [XLEN_W-1:0] xlen,
  output logic [ADDR_W-1:0] addr,
  output evr_desc_t         desc
);
  always_comb begin
    addr          = base + (ADDR_W'(idx) << EV_SHIFT);
    desc.xfer_len = xlen;
    desc.chan     = chan;
    desc.status   = status;
    desc.kind     = kind;
    desc.pad      = '0;
  end
endmodule

// File: rtl/evr_producer.sv
module evr_producer
  import evr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int EV_BYTES = 16,
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [IDX_W-1:0]  cfg_rp,
  input  logic [IDX_W-1:0]  cfg_wp,
  input  logic              db_valid,
  input  logic [IDX_W-1:0]  db_wp,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [KIND_W-1:0] ev_kind,
  input  logic [CHAN_W-1:0] ev_chan,
  input  logic [STAT_W-1:0] ev_status,
  input  logic [XLEN_W-1:0] ev_xlen,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DESC_W-1:0] mem_wdata,
  output logic              irq,
  output logic [IDX_W-1:0]  rd_ptr,
  output logic [IDX_W-1:0]  wr_ptr
);
  evr_state_e        state_q;
  evr_desc_t         desc_q, desc_d;
  logic [ADDR_W-1:0] base_q;
  logic              irq_q, full, accept, ack;

  assign ev_ready = (state_q == ST_IDLE) && !full;
  assign accept   = ev_valid && ev_ready;
  assign ack      = (state_q == ST_WRITE) && mem_wready;

  evr_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_len(cfg_len), .cfg_rp(cfg_rp), .cfg_wp(cfg_wp),
    .db_valid(db_valid), .db_wp(db_wp), .adv(ack),
    .rp(rd_ptr), .wp(wr_ptr), .full(full)
  );

  evr_fmt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .EV_BYTES(EV_BYTES)) u_fmt (
    .base(base_q), .idx(rd_ptr),
    .kind(ev_kind), .chan(ev_chan), .status(ev_status), .xlen(ev_xlen),
    .addr(mem_waddr), .desc(desc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      base_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= ack;
      if (cfg_load) base_q <= cfg_base;
      case (state_q)
        ST_IDLE: if (accept) begin
          desc_q  <= desc_d;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (mem_wready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_wvalid = (state_q == ST_WRITE);
  assign mem_wdata  = desc_q;
  assign irq        = irq_q;

  // R3: never accept into a full ring
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (rd_ptr != wr_ptr));

  // R6: write request held stable until acknowledged
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  // R7: device pointer moves only on a completed write
  a_r7_adv_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ptr != $past(rd_ptr)) && !$past(cfg_load)) |-> $past(mem_wvalid && mem_wready));

  // R8: interrupt follows an acknowledged write and lasts one cycle
  a_r8_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_wvalid && mem_wready));
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10: one outstanding write at most
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !ev_ready);
endmodule

// File: tb/tb_evr_producer.sv
module tb_evr_producer;
  localparam int IDX_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_len = '0;
  logic [3:0]  cfg_rp = '0, cfg_wp = '0;
  logic        db_valid = 1'b0;
  logic [3:0]  db_wp = '0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_kind = '0, ev_chan = '0, ev_status = '0;
  logic [15:0] ev_xlen = '0;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_waddr;
  logic [63:0] mem_wdata;
  logic        irq;
  logic [3:0]  rd_ptr, wr_ptr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_rp = 0, exp_wp = 0, exp_len = 16;
  logic [31:0] exp_base = '0;

  always #4 clk = ~clk;

  evr_producer #(.ADDR_W(32), .IDX_W(IDX_W), .EV_BYTES(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_rp(cfg_rp), .cfg_wp(cfg_wp),
    .db_valid(db_valid), .db_wp(db_wp),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_chan(ev_chan), .ev_status(ev_status), .ev_xlen(ev_xlen),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .irq(irq), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == exp_len - 1) ? 0 : p + 1;
  endfunction

  function automatic logic [63:0] pack(input logic [7:0] k, input logic [7:0] c,
                                       input logic [7:0] s, input logic [15:0] l);
    return {l, c, s, k, 24'h0};
  endfunction

  task automatic do_cfg(input logic [31:0] b, input int len, input int rp, input int wp);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = b; cfg_len = 5'(len); cfg_rp = 4'(rp); cfg_wp = 4'(wp);
    @(negedge clk);
    cfg_load = 1'b0;
    exp_base = b; exp_len = len; exp_rp = rp; exp_wp = wp;
    chk("R2 rd_ptr", 64'(rd_ptr), 64'(exp_rp));
    chk("R2 wr_ptr", 64'(wr_ptr), 64'(exp_wp));
    chk("R2 ev_ready", 64'(ev_ready), 64'(exp_rp != exp_wp));
  endtask

  task automatic do_db(input int v);
    @(negedge clk);
    db_valid = 1'b1; db_wp = 4'(v);
    @(negedge clk);
    db_valid = 1'b0;
    if (v < exp_len) exp_wp = v;
    chk("R9 wr_ptr after doorbell", 64'(wr_ptr), 64'(exp_wp));
  endtask

  // called at the falling edge just after the accepting rising edge
  task automatic finish_ev(input logic [7:0] k, input logic [7:0] c, input logic [7:0] s,
                           input logic [15:0] l, input int dly);
    logic [31:0] a;
    a = exp_base + 32'(exp_rp) * 32'd16;
    chk("R10 ev_ready low while writing", 64'(ev_ready), 64'd0);
    chk("R4 address", 64'(mem_waddr), 64'(a));
    chk("R5 descriptor", mem_wdata, pack(k, c, s, l));
    for (int i = 0; i < dly; i++) begin
      chk("R6 wvalid held", 64'(mem_wvalid), 64'd1);
      chk("R6 addr held", 64'(mem_waddr), 64'(a));
      chk("R8 no early irq", 64'(irq), 64'd0);
      chk("R7 no early advance", 64'(rd_ptr), 64'(exp_rp));
      @(negedge clk);
    end
    mem_wready = 1'b1;
    @(negedge clk);
    mem_wready = 1'b0;
    exp_rp = nxt(exp_rp);
    chk("R8 irq pulse", 64'(irq), 64'd1);
    chk("R7 rd_ptr advance", 64'(rd_ptr), 64'(exp_rp));
    chk("R6 wvalid dropped", 64'(mem_wvalid), 64'd0);
    @(negedge clk);
    chk("R8 irq one cycle", 64'(irq), 64'd0);
  endtask

  task automatic send(input logic [7:0] k, input logic [7:0] c, input logic [7:0] s,
                      input logic [15:0] l, input int dly);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_chan = c; ev_status = s; ev_xlen = l;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    finish_ev(k, c, s, l, dly);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 ev_ready", 64'(ev_ready), 64'd0);
    chk("R1 mem_wvalid", 64'(mem_wvalid), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 rd_ptr", 64'(rd_ptr), 64'd0);
    chk("R1 wr_ptr", 64'(wr_ptr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ev_ready after reset", 64'(ev_ready), 64'd0);

    // six-slot ring, empty: wp + 1 == rp
    do_cfg(32'h1000_0040, 6, 0, 5);
    send(8'h01, 8'h03, 8'h00, 16'h0200, 0);
    send(8'h02, 8'h00, 8'h01, 16'h0000, 1);
    send(8'h03, 8'h7f, 8'h05, 16'h1234, 2);
    send(8'hff, 8'hff, 8'hff, 16'hffff, 3);
    send(8'h01, 8'h21, 8'h00, 16'h0040, 0);

    // ring full now: rp == wp == 5
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 8'h02; ev_chan = 8'h44; ev_status = 8'h09; ev_xlen = 16'h0abc;
    for (int i = 0; i < 4; i++) begin
      chk("R3 ev_ready low when full", 64'(ev_ready), 64'd0);
      chk("R3 no write when full", 64'(mem_wvalid), 64'd0);
      @(negedge clk);
    end
    do_db(4);
    chk("R3 ready after release", 64'(ev_ready), 64'd1);
    @(negedge clk);
    ev_valid = 1'b0;
    finish_ev(8'h02, 8'h44, 8'h09, 16'h0abc, 1);
    chk("R7 wrapped to zero", 64'(rd_ptr), 64'd0);

    // out-of-range doorbells are ignored
    do_db(7);
    do_db(6);
    do_db(15);

    // random phase on a twelve-slot ring
    do_cfg(32'h2000_1000, 12, 10, 9);
    for (int it = 0; it < 60; it++) begin
      int unsigned r;
      r = $urandom;
      if (r[3:0] == 4'd0) do_db(12 + int'(r[5:4]));
      if (exp_rp == exp_wp || r[7:6] == 2'd0)
        do_db((exp_rp + exp_len - 1) % exp_len);
      send(8'(1 + (r[9:8] % 3)), r[17:10], r[25:18], 16'($urandom), int'(r[27:26]));
    end

    // drive to full, then check back-pressure once more
    while (exp_rp != exp_wp) send(8'h03, 8'h01, 8'h02, 16'h0003, 0);
    @(negedge clk);
    chk("R3 ev_ready low at full", 64'(ev_ready), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule